// File: doc/BRIEF.md
# Pipelined Vectoring CORDIC: Angle and Magnitude

This block converts a Cartesian pair (x, y) into polar form. It returns the four-quadrant angle atan2(y, x) and the vector length. The length is deliberately left multiplied by the CORDIC gain K ≈ 1.646760258121, so no multiplier is needed. Gain correction, if a consumer wants it, belongs downstream.

The datapath is fully unrolled and runs in vectoring mode. One microrotation stage per iteration drives y toward zero, and a register sits behind every stage, so a new sample can enter on every clock.

An entry stage first folds any left-half-plane vector onto the right half-plane by turning it through ±π. It seeds the angle accumulator with that ±π. An exit stage rounds away the guard bits and clamps the angle to the legal range. A valid bit travels alongside the data. A parameter selects whether x and y are two's-complement or unsigned. A second parameter decides whether the clock-enable input gates the pipeline or is ignored.

Top module: `cordic_vec_unit`

## Requirements
- R1: For signed inputs with x ≥ 0, `angle_o` equals atan2(y, x) within 3e-4 rad plus 2/|v| rad, where |v| is the vector length in input LSBs. `angle_o` is a two's-complement value in radians with ANG_FRAC fraction bits and a width of ANG_FRAC+3.
- R2: `mag_o` equals K·sqrt(x² + y²) within 3 LSB plus 2e-4 of the expected value, with K = 1.646760258121. `mag_o` is unsigned, IN_W+2 bits wide, and has the same LSB weight as the inputs. It does not overflow at any input corner, including x = y = −2^(IN_W−1).
- R3: For signed inputs with x < 0, the angle lies in the correct left-hand quadrant. It is near +π − atan(|y/x|) when y ≥ 0 and near −π + atan(|y/x|) when y < 0, within the R1 tolerance.
- R4: With signed inputs, `angle_o` never leaves [−round(π·2^ANG_FRAC), +round(π·2^ANG_FRAC)]. An input with y = 0 and x < 0 gives a positive angle next to +π.
- R5: With SIGNED_IN = 0, x and y are read as unsigned. `angle_o` then stays within [0, round(π/2·2^ANG_FRAC)] and matches atan2(y, x) within the R1 tolerance.
- R6: The input x = 0, y = 0 produces `angle_o` = 0 and `mag_o` = 0.
- R7: `valid_o` and the matching results appear exactly ITER+2 enabled clock edges after the sample is taken with `valid_i`. Bubbles (`valid_i` = 0) travel through as `valid_o` = 0.
- R8: With HAS_EN = 1, a clock edge with `en_i` = 0 changes no pipeline state, so `valid_o`, `angle_o` and `mag_o` hold. With HAS_EN = 0, `en_i` has no effect and the pipeline advances on every edge.
- R9: While `rst_ni` is low, `valid_o`, `angle_o` and `mag_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable for the whole pipeline (ignored when HAS_EN = 0) |
| valid_i | input | 1 | Marks x_i/y_i as a sample to convert |
| x_i | input | IN_W | x coordinate, signed or unsigned per SIGNED_IN |
| y_i | input | IN_W | y coordinate, signed or unsigned per SIGNED_IN |
| valid_o | output | 1 | Marks angle_o/mag_o as a result |
| angle_o | output | ANG_FRAC+3 | Angle in radians, two's complement, ANG_FRAC fraction bits |
| mag_o | output | IN_W+2 | K-scaled magnitude, unsigned, input LSB weight |

## Verification
The bench builds two instances side by side, each with IN_W = 16, ITER = 16, ANG_FRAC = 16 and GUARD = 4.

The first instance is signed, with 14 fraction bits and the enable honoured. Its full-scale negative corners exercise the headroom of the magnitude path. Exact ±π boundaries and all four quadrants reach the pre-rotation and the clamp, and stretches with the enable held low test the freeze.

The second instance is unsigned, with 16 fraction bits and the enable not built in. It shows the narrowed angle range at 0 and π/2. Because it keeps advancing while the first instance is frozen, it also shows that the enable input is ignored.

// File: rtl/cordic_vec_pkg.sv
package cordic_vec_pkg;

  localparam int ONE_SH = 60;
  localparam longint ONE = 64'sd1 <<< ONE_SH;

  // atan(1/m) scaled by 2^60, alternating power series
  function automatic longint atan_inv(input longint m);
    longint acc;
    longint p;
    longint n;
    bit     neg;
    bit     done;
    acc  = 0;
    p    = m;
    n    = 1;
    neg  = 1'b0;
    done = 1'b0;
    for (int k = 0; k < 64; k++) begin
      if (!done) begin
        if (p > ONE) done = 1'b1;
        else begin
          acc = neg ? acc - ((ONE / p) / n) : acc + ((ONE / p) / n);
          neg = !neg;
          n   = n + 2;
          if (p > (ONE / m) / m) done = 1'b1;
          else p = p * m * m;
        end
      end
    end
    return acc;
  endfunction

  function automatic longint round_sh(input longint raw, input int frac);
    return (raw + (64'sd1 <<< (ONE_SH - 1 - frac))) >>> (ONE_SH - frac);
  endfunction

  // atan(2^-i) at 'frac' fraction bits; atan(1) = atan(1/2) + atan(1/3)
  function automatic longint atan_fix(input int i, input int frac);
    longint raw;
    raw = (i == 0) ? atan_inv(2) + atan_inv(3) : atan_inv(64'sd1 <<< i);
    return round_sh(raw, frac);
  endfunction

  function automatic longint pi_fix(input int frac);
    return round_sh(4 * (atan_inv(2) + atan_inv(3)), frac);
  endfunction

  function automatic longint half_pi_fix(input int frac);
    return round_sh(2 * (atan_inv(2) + atan_inv(3)), frac);
  endfunction

endpackage

// File: rtl/cordic_vec_prerot.sv
module cordic_vec_prerot #(
  parameter int IN_W      = 16,
  parameter bit SIGNED_IN = 1'b1,
  parameter int GUARD     = 4,
  parameter int DW        = 23,
  parameter int AW        = 24,
  parameter int AF        = 20
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 vld_i,
  input  logic [IN_W-1:0]      x_i,
  input  logic [IN_W-1:0]      y_i,
  output logic                 vld_o,
  output logic                 zero_o,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] y_o,
  output logic signed [AW-1:0] z_o
);
  localparam int EXT_W = DW - IN_W - GUARD;
  localparam logic signed [AW-1:0] PI_Z = AW'(cordic_vec_pkg::pi_fix(AF));

  logic                 sx, sy;
  logic signed [DW-1:0] xw, yw, x_n, y_n;
  logic signed [AW-1:0] z_n;

  assign sx = SIGNED_IN && x_i[IN_W-1];
  assign sy = SIGNED_IN && y_i[IN_W-1];
  assign xw = {{EXT_W{sx}}, x_i, {GUARD{1'b0}}};
  assign yw = {{EXT_W{sy}}, y_i, {GUARD{1'b0}}};

  // left half-plane: turn by pi, seed accumulator with +/-pi
  always_comb begin
    if (xw[DW-1]) begin
      x_n = -xw;
      y_n = -yw;
      z_n = yw[DW-1] ? -PI_Z : PI_Z;
    end else begin
      x_n = xw;
      y_n = yw;
      z_n = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      zero_o <= 1'b0;
      x_o    <= '0;
      y_o    <= '0;
      z_o    <= '0;
    end else if (en_i) begin
      vld_o  <= vld_i;
      zero_o <= (x_i == '0) && (y_i == '0);
      x_o    <= x_n;
      y_o    <= y_n;
      z_o    <= z_n;
    end
  end

endmodule

// File: rtl/cordic_vec_stage.sv
module cordic_vec_stage #(
  parameter int     DW    = 23,
  parameter int     AW    = 24,
  parameter int     SHIFT = 0,
  parameter longint STEP  = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 vld_i,
  input  logic                 zero_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] y_i,
  input  logic signed [AW-1:0] z_i,
  output logic                 vld_o,
  output logic                 zero_o,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] y_o,
  output logic signed [AW-1:0] z_o
);
  localparam logic signed [AW-1:0] STEP_Z = AW'(STEP);

  logic signed [DW-1:0] x_n, y_n;
  logic signed [AW-1:0] z_n;

  // steer y toward zero
  always_comb begin
    if (!y_i[DW-1]) begin
      x_n = x_i + (y_i >>> SHIFT);
      y_n = y_i - (x_i >>> SHIFT);
      z_n = z_i + STEP_Z;
    end else begin
      x_n = x_i - (y_i >>> SHIFT);
      y_n = y_i + (x_i >>> SHIFT);
      z_n = z_i - STEP_Z;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      zero_o <= 1'b0;
      x_o    <= '0;
      y_o    <= '0;
      z_o    <= '0;
    end else if (en_i) begin
      vld_o  <= vld_i;
      zero_o <= zero_i;
      x_o    <= x_n;
      y_o    <= y_n;
      z_o    <= z_n;
    end
  end

  // the pre-rotation and growth headroom keep x non-negative in every stage
  assert_x_nonneg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |-> !x_i[DW-1]);

endmodule

// File: rtl/cordic_vec_out.sv
module cordic_vec_out #(
  parameter int DW        = 23,
  parameter int AW        = 24,
  parameter int GUARD     = 4,
  parameter int ANG_FRAC  = 16,
  parameter int ANG_W     = 19,
  parameter int MAG_W     = 18,
  parameter bit SIGNED_IN = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 vld_i,
  input  logic                 zero_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [AW-1:0] z_i,
  output logic                 valid_o,
  output logic [ANG_W-1:0]     angle_o,
  output logic [MAG_W-1:0]     mag_o
);
  localparam logic signed [AW-1:0] HALF_Z = AW'(64'sd1 <<< (GUARD - 1));
  localparam logic signed [DW-1:0] HALF_X = DW'(64'sd1 <<< (GUARD - 1));
  localparam logic signed [AW-1:0] HI_Z =
    AW'(SIGNED_IN ? cordic_vec_pkg::pi_fix(ANG_FRAC) : cordic_vec_pkg::half_pi_fix(ANG_FRAC));
  localparam logic signed [AW-1:0] LO_Z =
    AW'(SIGNED_IN ? -cordic_vec_pkg::pi_fix(ANG_FRAC) : 64'sd0);

  logic signed [AW-1:0] z_r, z_c;
  logic [MAG_W-1:0]     mag_n;

  assign z_r   = (z_i + HALF_Z) >>> GUARD;
  assign z_c   = (z_r > HI_Z) ? HI_Z : ((z_r < LO_Z) ? LO_Z : z_r);
  assign mag_n = MAG_W'((x_i + HALF_X) >>> GUARD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      angle_o <= '0;
      mag_o   <= '0;
    end else if (en_i) begin
      valid_o <= vld_i;
      angle_o <= zero_i ? '0 : ANG_W'(z_c);
      mag_o   <= mag_n;
    end
  end

  assert_valid_follow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (valid_o == $past(vld_i)));

endmodule

// File: rtl/cordic_vec_unit.sv
module cordic_vec_unit #(
  parameter int IN_W      = 16,
  parameter int FRAC_W    = 14,
  parameter bit SIGNED_IN = 1'b1,
  parameter bit HAS_EN    = 1'b1,
  parameter int ITER      = 16,
  parameter int ANG_FRAC  = 16,
  parameter int GUARD     = 4,
  localparam int ANG_W    = ANG_FRAC + 3,
  localparam int MAG_W    = IN_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             valid_i,
  input  logic [IN_W-1:0]  x_i,
  input  logic [IN_W-1:0]  y_i,
  output logic             valid_o,
  output logic [ANG_W-1:0] angle_o,
  output logic [MAG_W-1:0] mag_o
);
  localparam int DW = IN_W + 3 + GUARD;
  localparam int AF = ANG_FRAC + GUARD;
  localparam int AW = AF + 4;

  if ((SIGNED_IN && (IN_W < 4 || IN_W > 64)) || (!SIGNED_IN && (IN_W < FRAC_W || IN_W > 65))
      || ITER < 1 || ITER > 56 || GUARD < 1 || AF > 56) begin : g_bad_cfg
    initial $fatal(1, "cordic_vec_unit: unsupported parameter set");
  end

  logic en_eff;
  assign en_eff = en_i | !HAS_EN;

  logic                 vld_p  [ITER+1];
  logic                 zero_p [ITER+1];
  logic signed [DW-1:0] x_p    [ITER+1];
  logic signed [DW-1:0] y_p    [ITER+1];
  logic signed [AW-1:0] z_p    [ITER+1];

  cordic_vec_prerot #(
    .IN_W(IN_W), .SIGNED_IN(SIGNED_IN), .GUARD(GUARD), .DW(DW), .AW(AW), .AF(AF)
  ) u_prerot (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_eff), .vld_i(valid_i),
    .x_i(x_i), .y_i(y_i),
    .vld_o(vld_p[0]), .zero_o(zero_p[0]), .x_o(x_p[0]), .y_o(y_p[0]), .z_o(z_p[0])
  );

  for (genvar i = 0; i < ITER; i++) begin : g_stage
    cordic_vec_stage #(
      .DW(DW), .AW(AW), .SHIFT(i), .STEP(cordic_vec_pkg::atan_fix(i, AF))
    ) u_stage (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_eff),
      .vld_i(vld_p[i]), .zero_i(zero_p[i]), .x_i(x_p[i]), .y_i(y_p[i]), .z_i(z_p[i]),
      .vld_o(vld_p[i+1]), .zero_o(zero_p[i+1]),
      .x_o(x_p[i+1]), .y_o(y_p[i+1]), .z_o(z_p[i+1])
    );
  end

  logic unused_y;
  assign unused_y = ^y_p[ITER];

  cordic_vec_out #(
    .DW(DW), .AW(AW), .GUARD(GUARD), .ANG_FRAC(ANG_FRAC), .ANG_W(ANG_W),
    .MAG_W(MAG_W), .SIGNED_IN(SIGNED_IN)
  ) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_eff),
    .vld_i(vld_p[ITER]), .zero_i(zero_p[ITER]), .x_i(x_p[ITER]), .z_i(z_p[ITER]),
    .valid_o(valid_o), .angle_o(angle_o), .mag_o(mag_o)
  );

  assert_hold_on_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_eff |=> $stable(valid_o) && $stable(angle_o) && $stable(mag_o));

  assert_zero_mag_zero_angle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && mag_o == '0) |-> (angle_o == '0));

endmodule

// File: tb/cordic_vec_unit_tb.sv
`timescale 1ns/1ps
module cordic_vec_unit_tb;
  localparam int  IN_W = 16;
  localparam int  ITER = 16;
  localparam int  AFR  = 16;
  localparam int  LAT  = ITER + 2;
  localparam real KG   = 1.646760258121;
  localparam real PI   = 3.14159265358979;
  localparam real ASC  = 65536.0;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic vin = 1'b0;
  logic [IN_W-1:0] xs = '0, ys = '0, xu = '0, yu = '0;
  logic vs_o, vu_o;
  logic [AFR+2:0] as_o, au_o;
  logic [IN_W+1:0] ms_o, mu_o;

  cordic_vec_unit #(.IN_W(IN_W), .FRAC_W(14), .SIGNED_IN(1'b1), .HAS_EN(1'b1),
                    .ITER(ITER), .ANG_FRAC(AFR), .GUARD(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .valid_i(vin), .x_i(xs), .y_i(ys),
    .valid_o(vs_o), .angle_o(as_o), .mag_o(ms_o));

  cordic_vec_unit #(.IN_W(IN_W), .FRAC_W(16), .SIGNED_IN(1'b0), .HAS_EN(1'b0),
                    .ITER(ITER), .ANG_FRAC(AFR), .GUARD(4)) u_dut_uns (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .valid_i(vin), .x_i(xu), .y_i(yu),
    .valid_o(vu_o), .angle_o(au_o), .mag_o(mu_o));

  typedef struct { bit v; int x; int y; } ent_t;
  ent_t qs[$];
  ent_t qu[$];
  int   n_chk = 0, n_err = 0;
  bit   en_prev = 1'b1;
  bit   run = 1'b0;
  int   pi_lsb, hpi_lsb;

  initial begin
    pi_lsb  = $rtoi(PI * ASC + 0.5);
    hpi_lsb = $rtoi(PI / 2.0 * ASC + 0.5);
  end

  task automatic fail_r(input string req, input string what, input real act, input real exp);
    n_err++;
    $display("FAIL %s %s actual=%0f expected=%0f", req, what, act, exp);
  endtask

  task automatic chk_near(input string req, input string what, input real act, input real exp,
                          input real tol);
    n_chk++;
    if ((act - exp > tol) || (exp - act > tol)) fail_r(req, what, act, exp);
  endtask

  task automatic chk_true(input string req, input string what, input bit ok, input real act,
                          input real exp);
    n_chk++;
    if (!ok) fail_r(req, what, act, exp);
  endtask

  // behavioural pipeline model
  always @(posedge clk) begin
    if (!rst_n) begin
      qs.delete();
      qu.delete();
      for (int i = 0; i < LAT; i++) begin
        qs.push_back('{1'b0, 0, 0});
        qu.push_back('{1'b0, 0, 0});
      end
    end else begin
      if (en) begin
        qs.push_back('{vin, $signed(xs), $signed(ys)});
        void'(qs.pop_front());
      end
      qu.push_back('{vin, int'(xu), int'(yu)});
      void'(qu.pop_front());
    end
    en_prev <= en;
  end

  task automatic check_signed(input ent_t e);
    real a, m, vm, ea, em;
    a  = $itor($signed(as_o)) / ASC;
    m  = $itor(ms_o);
    vm = $sqrt($itor(e.x) * e.x + $itor(e.y) * e.y);
    if (e.x == 0 && e.y == 0) begin
      chk_true("R6", "zero angle", as_o == '0, a, 0.0);
      chk_true("R6", "zero mag", ms_o == '0, m, 0.0);
    end else begin
      ea = $atan2($itor(e.y), $itor(e.x));
      em = KG * vm;
      if (e.x < 0) chk_near("R3", "left angle", a, ea, 3.0e-4 + 2.0 / vm);
      else         chk_near("R1", "angle", a, ea, 3.0e-4 + 2.0 / vm);
      chk_near("R2", "mag", m, em, 3.0 + 2.0e-4 * em);
      chk_true("R4", "range", ($signed(as_o) <= pi_lsb) && ($signed(as_o) >= -pi_lsb),
               a, PI);
      if (e.y == 0 && e.x < 0)
        chk_true("R4", "y0 xneg positive", $signed(as_o) > 0, a, PI);
    end
  endtask

  task automatic check_unsigned(input ent_t e);
    real a, m, vm, ea, em;
    a  = $itor($signed(au_o)) / ASC;
    m  = $itor(mu_o);
    vm = $sqrt($itor(e.x) * e.x + $itor(e.y) * e.y);
    if (e.x == 0 && e.y == 0) begin
      chk_true("R6", "uns zero angle", au_o == '0, a, 0.0);
      chk_true("R6", "uns zero mag", mu_o == '0, m, 0.0);
    end else begin
      ea = $atan2($itor(e.y), $itor(e.x));
      em = KG * vm;
      chk_near("R5", "uns angle", a, ea, 3.0e-4 + 2.0 / vm);
      chk_near("R2", "uns mag", m, em, 3.0 + 2.0e-4 * em);
      chk_true("R5", "uns range", ($signed(au_o) >= 0) && ($signed(au_o) <= hpi_lsb),
               a, PI / 2.0);
    end
  endtask

  always @(negedge clk) begin
    if (run && rst_n) begin
      n_chk++;
      if (vs_o !== qs[0].v) fail_r(en_prev ? "R7" : "R8", "valid", vs_o, qs[0].v);
      else if (qs[0].v) check_signed(qs[0]);
      n_chk++;
      if (vu_o !== qu[0].v) fail_r(en_prev ? "R7" : "R8", "uns valid", vu_o, qu[0].v);
      else if (qu[0].v) check_unsigned(qu[0]);
    end
  end

  task automatic drive(input bit v, input int x, input int y, input int ux, input int uy);
    vin = v;
    xs  = IN_W'(x);
    ys  = IN_W'(y);
    xu  = IN_W'(ux);
    yu  = IN_W'(uy);
  endtask

  int dx[16] = '{0, 16384, 0, -16384, 0, 16384, -16384, -16384, 16384, -32768, 32767,
                 -32768, -32768, -32768, 3, -1};
  int dy[16] = '{0, 0, 16384, 0, -16384, 16384, 16384, -16384, -16384, -32768, 32767,
                 0, 1, -1, -4, 0};
  int ux[8]  = '{0, 65535, 0, 65535, 1, 0, 40000, 123};
  int uy[8]  = '{0, 0, 65535, 65535, 0, 1, 300, 60000};

  initial begin
    logic        s_v;
    logic [18:0] s_a;
    logic [17:0] s_m;
    // R9: reset state
    repeat (3) begin
      @(negedge clk);
      chk_true("R9", "reset valid", !vs_o && !vu_o, vs_o, 0.0);
      chk_true("R9", "reset angle", as_o == '0 && au_o == '0, $itor(as_o), 0.0);
      chk_true("R9", "reset mag", ms_o == '0 && mu_o == '0, $itor(ms_o), 0.0);
    end
    rst_n = 1'b1;
    run   = 1'b1;
    for (int i = 0; i < 16; i++) begin
      drive(1'b1, dx[i], dy[i], ux[i % 8], uy[i % 8]);
      @(negedge clk);
    end
    // R8: freeze with data in flight
    drive(1'b1, 1000, -2000, 5, 7);
    @(negedge clk);
    s_v = vs_o; s_a = as_o; s_m = ms_o;
    en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      drive(1'b1, -500 * i, 77, 900 * i, 31);
      @(negedge clk);
      chk_true("R8", "freeze valid", vs_o == s_v, vs_o, s_v);
      chk_true("R8", "freeze angle", as_o == s_a, $itor(as_o), $itor(s_a));
      chk_true("R8", "freeze mag", ms_o == s_m, $itor(ms_o), $itor(s_m));
    end
    en = 1'b1;
    drive(1'b0, 0, 0, 0, 0);
    repeat (LAT + 2) @(negedge clk);
    // random traffic with bubbles and stalls
    for (int i = 0; i < 3000; i++) begin
      en = ($urandom % 8) != 0;
      drive(($urandom % 4) != 0, $signed(IN_W'($urandom)), $signed(IN_W'($urandom)),
            int'(IN_W'($urandom)), int'(IN_W'($urandom)));
      @(negedge clk);
    end
    en = 1'b1;
    drive(1'b0, 0, 0, 0, 0);
    repeat (LAT + 2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_err++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule